// File: doc/BRIEF.md
# Out-of-Order Retirement Selector

This block looks at the oldest slots of a reorder buffer each cycle and decides which of them can retire now, even while older slots are still pending. Every slot supplies a small status record: occupied, finished, branch with its resolution state, memory access with its address and ordering state, exception and may-trap flags, the architectural register it writes, and its source registers with read-pending flags. Hazards raised by a slot are passed to every younger slot through prefix OR chains. The result is a one-hot-per-slot retire vector, registered, and capped at the retire width.

Slot 0 of every per-slot vector is the oldest entry, the head of the buffer. The retire logic of the surrounding core frees whatever the vector selects. A pending asynchronous interrupt turns the selector into a strict in-order selector, so that the machine can drain to a consistent point. A sequential-consistency input adds an ordering rule between memory accesses.

Top module: `ooc_commit_pick`

## Requirements
- R1: While reset is high the retire vector is all zero; outside reset the vector seen after a rising edge reflects the slot inputs present at that edge (one register stage).
- R2: A bit is set only for a slot that is occupied, finished and whose own exception flag is clear.
- R3: A slot is not selected while any older occupied slot is a branch that is not yet resolved.
- R4: A slot is not selected while any older occupied slot is a memory access whose address is not yet generated.
- R5: A slot that writes architectural register R is not selected while an older occupied slot still has a pending read of R on any of its sources.
- R6: A slot is not selected while an older occupied slot has its exception flag set, or is unfinished with its may-trap flag set.
- R7: With sequential consistency on, a memory access is not selected while an older occupied memory access is not yet ordered; with it off, ordering has no effect.
- R8: At most CW bits are set; when more slots qualify, the CW oldest qualifying slots are chosen.
- R9: While an interrupt is pending, only a contiguous run of qualifying slots starting at slot 0 is selected.
- R10: Without an interrupt pending, a qualifying slot is selected even if an older slot is unfinished.
- R11: An unoccupied slot raises no hazard for younger slots, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | Asynchronous interrupt pending: strict in-order selection |
| seq_cons | input | 1 | Sequential-consistency ordering rule enabled |
| ent_valid | input | WIN | Slot occupied, bit 0 = oldest |
| ent_done | input | WIN | Slot finished execution |
| ent_branch | input | WIN | Slot is a branch |
| ent_resolved | input | WIN | Branch direction and target resolved |
| ent_mem | input | WIN | Slot is a memory access |
| ent_addr_ok | input | WIN | Physical address generated and translated |
| ent_ordered | input | WIN | Memory access globally ordered |
| ent_exc | input | WIN | Exception flag recorded for the slot |
| ent_may_trap | input | WIN | Slot could still raise an exception when it finishes |
| ent_wr | input | WIN | Slot writes an architectural register |
| ent_dst | input | WIN*AW | Destination register of slot i at bits [i*AW +: AW] |
| ent_src | input | WIN*NSRC*AW | Source k of slot i at bits [(i*NSRC+k)*AW +: AW] |
| ent_src_pend | input | WIN*NSRC | Read of source k of slot i still pending, bit i*NSRC+k |
| commit_vec | output | WIN | Registered retire vector, bit 0 = oldest |

## Verification
The checker tests on every cycle that the vector never exceeds the width cap, never selects an unoccupied, unfinished or excepting slot, never selects past an older unresolved branch or address-less memory access, is zero after reset, and is a contiguous head run whenever an interrupt was pending. The register-read hazard, the may-trap and ordering rules, the choice of the oldest slots under the cap and the invisibility of empty slots are shown by the bench's directed scenarios and by random records compared against a reference function.

// File: rtl/ooc_pkg.sv
package ooc_pkg;

    localparam int DEF_WIN  = 16;
    localparam int DEF_CW   = 8;
    localparam int DEF_AW   = 5;
    localparam int DEF_NSRC = 2;

    // per-slot status flags
    typedef struct packed {
        logic valid;
        logic done;
        logic branch;
        logic resolved;
        logic mem;
        logic addr_ok;
        logic ordered;
        logic exc;
        logic may_trap;
        logic wr;
    } slot_flags_t;

    // hazard kinds a slot can impose on all younger slots
    typedef enum int {
        HZ_BRANCH = 0,
        HZ_ADDR   = 1,
        HZ_TRAP   = 2,
        HZ_ORDER  = 3,
        HZ_NUM    = 4
    } hazard_e;

    function automatic logic [HZ_NUM-1:0] slot_hazards(input slot_flags_t f);
        logic [HZ_NUM-1:0] h;
        h            = '0;
        h[HZ_BRANCH] = f.valid & f.branch & ~f.resolved;
        h[HZ_ADDR]   = f.valid & f.mem & ~f.addr_ok;
        h[HZ_TRAP]   = f.valid & (f.exc | (~f.done & f.may_trap));
        h[HZ_ORDER]  = f.valid & f.mem & ~f.ordered;
        return h;
    endfunction

endpackage

// File: rtl/ooc_older_or.sv
module ooc_older_or #(
    parameter int N = 16
) (
    input  logic [N-1:0] blk,
    output logic [N-1:0] older_any
);
    // older_any[i] = OR of blk over all slots older than i
    assign older_any[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign older_any[i] = older_any[i-1] | blk[i-1];
        end
    endgenerate
endmodule

// File: rtl/ooc_war_scan.sv
module ooc_war_scan #(
    parameter int N    = 16,
    parameter int NSRC = 2,
    parameter int AW   = 5
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0]         wr,
    input  logic [N*AW-1:0]      dst,
    input  logic [N*NSRC*AW-1:0] src,
    input  logic [N*NSRC-1:0]    pend,
    output logic [N-1:0]         war
);
    localparam int NRD = N * NSRC;

    logic [NRD-1:0] rd_live;
    assign rd_live = pend & {NSRC{1'b0}} | pend & expand_valid(valid);

    function automatic logic [NRD-1:0] expand_valid(input logic [N-1:0] v);
        logic [NRD-1:0] r;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < NSRC; k++)
                r[i*NSRC+k] = v[i];
        return r;
    endfunction

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int r = 0; r < i * NSRC; r++) begin
                    if (rd_live[r] && (src[r*AW +: AW] == dst[i*AW +: AW]))
                        hit = 1'b1;
                end
            end
            assign war[i] = wr[i] & hit;
        end
    endgenerate
endmodule

// File: rtl/ooc_cap_sel.sv
module ooc_cap_sel #(
    parameter int N  = 16,
    parameter int CW = 8
) (
    input  logic [N-1:0] cand,
    input  logic         in_order,
    output logic [N-1:0] sel
);
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] CAP = (CW >= N) ? CNT_W'(N) : CNT_W'(CW);

    always_comb begin
        logic [CNT_W-1:0] taken;
        logic             run;
        logic             pick;
        taken = '0;
        run   = 1'b1;
        for (int i = 0; i < N; i++) begin
            run    = run & cand[i];
            pick   = in_order ? run : cand[i];
            sel[i] = pick && (taken < CAP);
            if (sel[i]) taken = taken + 1'b1;
        end
    end
endmodule

// File: rtl/ooc_commit_pick.sv
module ooc_commit_pick
    import ooc_pkg::*;
#(
    parameter int WIN  = DEF_WIN,
    parameter int CW   = DEF_CW,
    parameter int AW   = DEF_AW,
    parameter int NSRC = DEF_NSRC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   irq_pend,
    input  logic                   seq_cons,
    input  logic [WIN-1:0]         ent_valid,
    input  logic [WIN-1:0]         ent_done,
    input  logic [WIN-1:0]         ent_branch,
    input  logic [WIN-1:0]         ent_resolved,
    input  logic [WIN-1:0]         ent_mem,
    input  logic [WIN-1:0]         ent_addr_ok,
    input  logic [WIN-1:0]         ent_ordered,
    input  logic [WIN-1:0]         ent_exc,
    input  logic [WIN-1:0]         ent_may_trap,
    input  logic [WIN-1:0]         ent_wr,
    input  logic [WIN*AW-1:0]      ent_dst,
    input  logic [WIN*NSRC*AW-1:0] ent_src,
    input  logic [WIN*NSRC-1:0]    ent_src_pend,
    output logic [WIN-1:0]         commit_vec
);
    slot_flags_t     flags [WIN];
    logic [WIN-1:0]  hz_src   [HZ_NUM];
    logic [WIN-1:0]  hz_older [HZ_NUM];
    logic [WIN-1:0]  war;
    logic [WIN-1:0]  cand;
    logic [WIN-1:0]  sel;

    generate
        for (genvar i = 0; i < WIN; i++) begin : g_slot
            logic [HZ_NUM-1:0] h;
            assign flags[i] = '{valid:    ent_valid[i],
                                done:     ent_done[i],
                                branch:   ent_branch[i],
                                resolved: ent_resolved[i],
                                mem:      ent_mem[i],
                                addr_ok:  ent_addr_ok[i],
                                ordered:  ent_ordered[i],
                                exc:      ent_exc[i],
                                may_trap: ent_may_trap[i],
                                wr:       ent_wr[i]};
            assign h = slot_hazards(flags[i]);
            for (genvar k = 0; k < HZ_NUM; k++) begin : g_kind
                assign hz_src[k][i] = h[k];
            end
            assign cand[i] = flags[i].valid & flags[i].done & ~flags[i].exc
                           & ~hz_older[HZ_BRANCH][i]
                           & ~hz_older[HZ_ADDR][i]
                           & ~hz_older[HZ_TRAP][i]
                           & ~(seq_cons & flags[i].mem & hz_older[HZ_ORDER][i])
                           & ~war[i];
        end

        for (genvar k = 0; k < HZ_NUM; k++) begin : g_chain
            ooc_older_or #(.N(WIN)) u_or (
                .blk       (hz_src[k]),
                .older_any (hz_older[k])
            );
        end
    endgenerate

    ooc_war_scan #(.N(WIN), .NSRC(NSRC), .AW(AW)) u_war (
        .valid (ent_valid),
        .wr    (ent_wr),
        .dst   (ent_dst),
        .src   (ent_src),
        .pend  (ent_src_pend),
        .war   (war)
    );

    ooc_cap_sel #(.N(WIN), .CW(CW)) u_cap (
        .cand     (cand),
        .in_order (irq_pend),
        .sel      (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) commit_vec <= '0;
        else     commit_vec <= sel;
    end
endmodule

// File: rtl/ooc_commit_pick_chk.sv
module ooc_commit_pick_chk #(
    parameter int WIN = 16,
    parameter int CW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           irq_pend,
    input logic [WIN-1:0] ent_valid,
    input logic [WIN-1:0] ent_done,
    input logic [WIN-1:0] ent_branch,
    input logic [WIN-1:0] ent_resolved,
    input logic [WIN-1:0] ent_mem,
    input logic [WIN-1:0] ent_addr_ok,
    input logic [WIN-1:0] ent_exc,
    input logic [WIN-1:0] commit_vec
);
    logic [WIN-1:0] p_ok;
    logic [WIN-1:0] p_br_blk;
    logic [WIN-1:0] p_ad_blk;
    logic           p_irq;
    logic [WIN-1:0] br_blk;
    logic [WIN-1:0] ad_blk;

    // nested scan, independent of the prefix chains in the design
    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            br_blk[i] = 1'b0;
            ad_blk[i] = 1'b0;
            for (int j = 0; j < WIN; j++) begin
                if (j < i && ent_valid[j] && ent_branch[j] && !ent_resolved[j]) br_blk[i] = 1'b1;
                if (j < i && ent_valid[j] && ent_mem[j] && !ent_addr_ok[j])     ad_blk[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        p_ok     <= ent_valid & ent_done & ~ent_exc;
        p_br_blk <= br_blk;
        p_ad_blk <= ad_blk;
        p_irq    <= irq_pend;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (commit_vec == '0));

    assert_width_cap_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(commit_vec) <= CW);

    assert_only_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((commit_vec & ~p_ok) == '0));

    assert_branch_guard_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((commit_vec & p_br_blk) == '0));

    assert_addr_guard_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((commit_vec & p_ad_blk) == '0));

    assert_head_run_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && p_irq) |-> ((commit_vec & (commit_vec + 1'b1)) == '0));
endmodule

bind ooc_commit_pick ooc_commit_pick_chk #(.WIN(WIN), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_pend     (irq_pend),
    .ent_valid    (ent_valid),
    .ent_done     (ent_done),
    .ent_branch   (ent_branch),
    .ent_resolved (ent_resolved),
    .ent_mem      (ent_mem),
    .ent_addr_ok  (ent_addr_ok),
    .ent_exc      (ent_exc),
    .commit_vec   (commit_vec)
);

// File: tb/ooc_commit_pick_bench.sv
module ooc_commit_pick_bench;
    localparam int WIN = 16, CW = 8, AW = 5, NSRC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_pend = 1'b0, seq_cons = 1'b0;
    logic [WIN-1:0] v, dn, br, rs, mm, ad, od, ex, mt, wr;
    logic [WIN*AW-1:0]      dst;
    logic [WIN*NSRC*AW-1:0] src;
    logic [WIN*NSRC-1:0]    pend;
    logic [WIN-1:0]         commit_vec;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    ooc_commit_pick u_ooc_commit_pick (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .seq_cons(seq_cons),
        .ent_valid(v), .ent_done(dn), .ent_branch(br), .ent_resolved(rs),
        .ent_mem(mm), .ent_addr_ok(ad), .ent_ordered(od), .ent_exc(ex),
        .ent_may_trap(mt), .ent_wr(wr), .ent_dst(dst), .ent_src(src),
        .ent_src_pend(pend), .commit_vec(commit_vec)
    );

    function automatic logic [WIN-1:0] model();
        logic [WIN-1:0] ok, res;
        int n;
        bit run;
        for (int i = 0; i < WIN; i++) begin
            ok[i] = v[i] & dn[i] & ~ex[i];
            for (int j = 0; j < i; j++) begin
                if (v[j]) begin
                    if (br[j] && !rs[j]) ok[i] = 1'b0;
                    if (mm[j] && !ad[j]) ok[i] = 1'b0;
                    if (ex[j] || (!dn[j] && mt[j])) ok[i] = 1'b0;
                    if (seq_cons && mm[i] && mm[j] && !od[j]) ok[i] = 1'b0;
                    for (int k = 0; k < NSRC; k++)
                        if (wr[i] && pend[j*NSRC+k] &&
                            src[(j*NSRC+k)*AW +: AW] == dst[i*AW +: AW]) ok[i] = 1'b0;
                end
            end
        end
        res = '0; n = 0; run = 1;
        for (int i = 0; i < WIN; i++) begin
            run = run & ok[i];
            if ((irq_pend ? run : ok[i]) && n < CW) begin res[i] = 1'b1; n++; end
        end
        return res;
    endfunction

    task automatic clear_all();
        v = '0; dn = '0; br = '0; rs = '0; mm = '0; ad = '0; od = '0;
        ex = '0; mt = '0; wr = '0; dst = '0; src = '0; pend = '0;
        irq_pend = 1'b0; seq_cons = 1'b0;
    endtask

    task automatic check(input logic [WIN-1:0] exp, input string req);
        checks++;
        if (commit_vec !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, commit_vec, exp);
        end
    endtask

    // inputs already set at a falling edge; result is visible after the next rise
    task automatic apply(input logic [WIN-1:0] exp, input string req);
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
        if (model() !== exp) begin
            checks++; failures++;
            $display("FAIL %s reference=%h expected=%h", req, model(), exp);
        end
    endtask

    initial begin : wdog
        #(8 * 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [WIN-1:0] e;
        clear_all();
        v = '1; dn = '1;
        repeat (3) @(negedge clk);
        check('0, "R1 reset holds zero");
        rst = 1'b0;

        // R8 R10: everything ready, cap keeps oldest eight
        clear_all(); v = '1; dn = '1;
        apply(16'h00FF, "R8 cap oldest");

        // R10: head unfinished, younger finished slots retire
        clear_all(); v = 16'h000F; dn = 16'h000E;
        apply(16'h000E, "R10 past unfinished head");
        irq_pend = 1'b1;
        apply(16'h0000, "R9 irq blocks past head");
        clear_all(); v = '1; dn = 16'hFFFD;
        apply(16'h01FD, "R10 gap at slot1");
        irq_pend = 1'b1;
        apply(16'h0001, "R9 head run only");

        // R3
        clear_all(); v = '1; dn = '1; br[2] = 1'b1;
        apply(16'h0007, "R3 unresolved branch");
        rs[2] = 1'b1;
        apply(16'h00FF, "R3 resolved branch");

        // R4
        clear_all(); v = '1; dn = '1; mm[3] = 1'b1;
        apply(16'h000F, "R4 address pending");

        // R5
        clear_all(); v = '1; dn = '1;
        src[(1*NSRC+0)*AW +: AW] = 5'd5; pend[1*NSRC+0] = 1'b1;
        wr[4] = 1'b1; dst[4*AW +: AW] = 5'd5;
        apply(16'h01EF, "R5 pending read");
        pend[1*NSRC+0] = 1'b0;
        apply(16'h00FF, "R5 read done");

        // R2 R6
        clear_all(); v = '1; dn = '1; ex[2] = 1'b1;
        apply(16'h0003, "R2 R6 exception flag");
        clear_all(); v = '1; dn = 16'hFFFD; mt[1] = 1'b1;
        apply(16'h0001, "R6 may trap unfinished");

        // R7
        clear_all(); v = '1; dn = '1; mm[3:1] = 3'b111; ad = '1; od = '1; od[1] = 1'b0;
        seq_cons = 1'b1;
        apply(16'h03F3, "R7 seq consistency");
        seq_cons = 1'b0;
        apply(16'h00FF, "R7 relaxed ordering");

        // R11 R2: empty head full of hazard fields
        clear_all(); v = 16'hFFFE; dn = 16'hFFFE;
        br[0] = 1'b1; mm[0] = 1'b1; ex[0] = 1'b1; mt[0] = 1'b1; od[0] = 1'b0;
        src[0 +: AW] = 5'd3; pend[0] = 1'b1; wr = '1; dst = '0; dst[1*AW +: AW] = 5'd3;
        seq_cons = 1'b1; mm[1] = 1'b1; ad[1] = 1'b1; od[1] = 1'b1;
        apply(16'h01FE, "R11 empty slot silent");

        // random records
        void'($urandom(32'd4242));
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < WIN; i++) begin
                v[i]  = ($urandom % 8) != 0;
                dn[i] = ($urandom % 5) != 0;
                br[i] = ($urandom % 7) == 0;
                rs[i] = ($urandom % 2) == 0;
                mm[i] = ($urandom % 3) == 0;
                ad[i] = ($urandom % 6) != 0;
                od[i] = ($urandom % 4) != 0;
                ex[i] = ($urandom % 40) == 0;
                mt[i] = ($urandom % 8) == 0;
                wr[i] = ($urandom % 2) == 0;
                dst[i*AW +: AW] = AW'($urandom % 8);
                for (int k = 0; k < NSRC; k++) begin
                    src[(i*NSRC+k)*AW +: AW] = AW'($urandom % 8);
                    pend[i*NSRC+k] = ($urandom % 6) == 0;
                end
            end
            irq_pend = ($urandom % 6) == 0;
            seq_cons = ($urandom % 2) == 0;
            e = model();
            @(posedge clk);
            @(negedge clk);
            check(e, "R2-random R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule